// File: doc/BRIEF.md
# Registered Bus Transceiver

This block moves a data word between two bidirectional ports, A and B, over two independent paths: A-to-B and B-to-A. Each path keeps one storage bit per data bit, and that storage acts in one of two ways. While the path's latch-enable pin is high, the storage is transparent. While the latch enable is low, the storage loads only on a low-to-high transition of the path's bus clock. When the latch enable is low and the bus clock is steady, the storage holds its value. A high latch enable takes precedence over the bus clock.

The latch-enable and bus-clock pins arrive asynchronously. A fast system clock samples them through a two-flop synchroniser, and an edge detector on the synchronised clock produces the capture strobe. The data pins go straight to the storage. For that reason, data must be stable for a few system cycles around each control change.

Port B is driven when its drive enable is high. Port A is driven when its drive enable is low. Each port has a separate input bus, an output bus and a drive flag, so the block itself contains no internal tristate. A pad ring combines these three signals into a bidirectional pin. A synchronous reset clears both storage words and keeps both drive flags low until one cycle after reset is released.

Top module: `regxcvr`

## Requirements
- R1: While `rst` is high, both storage words are cleared to zero at each system clock edge. `bDrive` and `aDrive` are low from the edge after `rst` is first sampled high until the first edge at which it is sampled low.
- R2: While `leAB` is high, the storage that drives `bOut` reloads from `aIn` on every system clock edge, so `bOut` follows `aIn`.
- R3: While `leAB` is low and `clkAB` does not rise, `bOut` keeps its value whatever `aIn` does. This holds with `clkAB` steady low and with it steady high.
- R4: While `leAB` is low, a low-to-high transition of `clkAB` loads the value present on `aIn` into the A-to-B storage.
- R5: A high-to-low transition of `clkAB` while `leAB` is low leaves `bOut` unchanged.
- R6: Out of reset, `bDrive` equals `oeAB` (active high). When `oeAB` is low, `bDrive` is low whatever the other inputs are, while the stored value is kept.
- R7: Out of reset, `aDrive` is high exactly when `oeBA_n` is low (active low).
- R8: The B-to-A path behaves like the A-to-B path in every mode of R2 to R5. It uses `leBA`, `clkBA`, `bIn` and `aOut`.
- R9: When `leAB` falls while `clkAB` is high, `bOut` keeps the value it had at the fall for as long as `clkAB` stays high.
- R10: The A-to-B storage loads only from `aIn` and the B-to-A storage only from `bIn`. Activity on one path's controls never changes the other path's output, even with both drive flags high.
- R11: A change on a latch-enable or bus-clock pin takes effect in storage at the third system clock edge after the change. The output is unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control pins |
| rst | input | 1 | Synchronous reset, active high |
| leAB | input | 1 | A-to-B latch enable; high makes the path transparent |
| clkAB | input | 1 | A-to-B bus clock; a rising edge captures |
| oeAB | input | 1 | Port B drive enable, active high |
| leBA | input | 1 | B-to-A latch enable |
| clkBA | input | 1 | B-to-A bus clock |
| oeBA_n | input | 1 | Port A drive enable, active low |
| aIn | input | WIDTH | Value sensed on port A pins |
| bIn | input | WIDTH | Value sensed on port B pins |
| bOut | output | WIDTH | Value to drive on port B |
| bDrive | output | 1 | High when port B pins are driven |
| aOut | output | WIDTH | Value to drive on port A |
| aDrive | output | 1 | High when port A pins are driven |

## Verification
The bench goes after the places where latch mode and register mode meet.

- If the latch enable drops while the bus clock is high and the design treats that as a capture, the output moves to data that arrived after the fall.
- If the design captures on a falling bus clock, data changes while the clock is low leak through.
- If the edge detector lacks its history flop, a clock held high keeps reloading the storage.

The bench also runs both drive flags at once with different words on each side. A path fed from the wrong bus, or from its own output, then shows up as a wrong word. Finally, the bench counts the cycles from a control change to the output change, so an added or missing synchroniser stage is caught, as is a drive flag that is active during reset.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;
  // Strobes passed from the control unit to the storage datapath
  typedef struct packed {
    logic loadAB;   // A-to-B storage loads from the A input bus
    logic loadBA;   // B-to-A storage loads from the B input bus
    logic driveB;   // port B driven
    logic driveA;   // port A driven
  } xcvrStrobe_t;

  localparam int NUM_PATHS = 2;
  localparam int PATH_AB   = 0;
  localparam int PATH_BA   = 1;
endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic lePin,
  input  logic clkPin,
  output logic leLvl,
  output logic clkRise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] leChain;
  logic [TOP:0] clkChain;
  logic         clkPrev;

  // Plain samplers: no reset needed, reset holds off their use downstream
  always_ff @(posedge clk) begin
    leChain  <= {leChain[TOP-1:0], lePin};
    clkChain <= {clkChain[TOP-1:0], clkPin};
    clkPrev  <= clkChain[TOP];
  end

  assign leLvl   = leChain[TOP];
  assign clkRise = clkChain[TOP] & ~clkPrev;
endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import regxcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        leAB,
  input  logic        clkAB,
  input  logic        oeAB,
  input  logic        leBA,
  input  logic        clkBA,
  input  logic        oeBA_n,
  output xcvrStrobe_t strobe
);
  logic [NUM_PATHS-1:0] lePins;
  logic [NUM_PATHS-1:0] clkPins;
  logic [NUM_PATHS-1:0] leLvl;
  logic [NUM_PATHS-1:0] clkRise;
  logic [NUM_PATHS-1:0] load;
  logic                 live;

  assign lePins[PATH_AB]  = leAB;
  assign lePins[PATH_BA]  = leBA;
  assign clkPins[PATH_AB] = clkAB;
  assign clkPins[PATH_BA] = clkBA;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xcvr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .lePin  (lePins[p]),
      .clkPin (clkPins[p]),
      .leLvl  (leLvl[p]),
      .clkRise(clkRise[p])
    );
    // Transparent level wins over the edge; both load the same input
    assign load[p] = live & (leLvl[p] | clkRise[p]);
  end

  // Outputs stay quiet until the cycle after reset is released
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  always_comb begin
    strobe.loadAB = load[PATH_AB];
    strobe.loadBA = load[PATH_BA];
    strobe.driveB = live & oeAB;
    strobe.driveA = live & ~oeBA_n;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import regxcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] storeAB,
  output logic [WIDTH-1:0] storeBA
);
  // Each storage word is fed only from the opposite port's sensed pins
  always_ff @(posedge clk) begin
    if (rst)                storeAB <= '0;
    else if (strobe.loadAB) storeAB <= aIn;
  end

  always_ff @(posedge clk) begin
    if (rst)                storeBA <= '0;
    else if (strobe.loadBA) storeBA <= bIn;
  end
endmodule

// File: rtl/regxcvr.sv
module regxcvr
  import regxcvr_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             leAB,
  input  logic             clkAB,
  input  logic             oeAB,
  input  logic             leBA,
  input  logic             clkBA,
  input  logic             oeBA_n,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);
  xcvrStrobe_t strobe;

  xcvr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .leAB  (leAB),
    .clkAB (clkAB),
    .oeAB  (oeAB),
    .leBA  (leBA),
    .clkBA (clkBA),
    .oeBA_n(oeBA_n),
    .strobe(strobe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .storeAB(bOut),
    .storeBA(aOut)
  );

  assign bDrive = strobe.driveB;
  assign aDrive = strobe.driveA;
endmodule

// File: rtl/regxcvr_chk.sv
module regxcvr_chk #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             leAB,
  input logic             clkAB,
  input logic             oeAB,
  input logic             leBA,
  input logic             clkBA,
  input logic             oeBA_n,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic             bDrive,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive
);
  localparam int LAT  = SYNC_STAGES;
  localparam int LAT1 = SYNC_STAGES + 1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (bOut == '0 && aOut == '0 && !bDrive && !aDrive));

  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(leAB, LAT)) |=> (bOut == $past(aIn)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(leAB, LAT) && !($past(clkAB, LAT) && !$past(clkAB, LAT1)))
      |=> $stable(bOut));

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clkAB, LAT) && !$past(clkAB, LAT1))
      |=> (bOut == $past(aIn)));

  p_drive_b_r6: assert property (@(posedge clk) disable iff (rst)
    !oeAB |-> !bDrive);

  p_drive_a_r7: assert property (@(posedge clk) disable iff (rst)
    oeBA_n |-> !aDrive);

  p_capture_ba_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(leBA, LAT) || ($past(clkBA, LAT) && !$past(clkBA, LAT1))))
      |=> (aOut == $past(bIn)));
endmodule

bind regxcvr regxcvr_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst(rst), .leAB(leAB), .clkAB(clkAB), .oeAB(oeAB),
  .leBA(leBA), .clkBA(clkBA), .oeBA_n(oeBA_n), .aIn(aIn), .bIn(bIn),
  .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
);

// File: tb/regxcvr_tb_top.sv
`timescale 1ns/1ps
module regxcvr_tb_top;
  localparam int W = 18;
  localparam int NVEC = 12;
  // {leAB, clkAB, oeAB, aIn, expected bOut, expected bDrive}
  localparam logic [2*W+3:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 18'h15A5A, 18'h15A5A, 1'b1},  // R2
    {1'b1, 1'b0, 1'b1, 18'h2A5A5, 18'h2A5A5, 1'b1},  // R2
    {1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h2A5A5, 1'b1},  // R3 clock low
    {1'b0, 1'b1, 1'b1, 18'h00001, 18'h3FFFF, 1'b1},  // R4
    {1'b0, 1'b1, 1'b1, 18'h00002, 18'h3FFFF, 1'b1},  // R3 clock high
    {1'b0, 1'b0, 1'b1, 18'h00003, 18'h3FFFF, 1'b1},  // R5
    {1'b0, 1'b1, 1'b0, 18'h00004, 18'h00003, 1'b0},  // R4 R6
    {1'b1, 1'b1, 1'b0, 18'h12345, 18'h12345, 1'b0},  // R2 R6
    {1'b0, 1'b1, 1'b1, 18'h0F0F0, 18'h12345, 1'b1},  // R9
    {1'b0, 1'b0, 1'b1, 18'h0AAAA, 18'h12345, 1'b1},  // R5
    {1'b0, 1'b1, 1'b1, 18'h05555, 18'h0AAAA, 1'b1},  // R4
    {1'b1, 1'b1, 1'b1, 18'h00000, 18'h00000, 1'b1}   // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic leAB = 1'b0, clkAB = 1'b0, oeAB = 1'b1;
  logic leBA = 1'b0, clkBA = 1'b0, oeBA_n = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] bOut, aOut;
  logic bDrive, aDrive;
  int nTests = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  regxcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .leAB(leAB), .clkAB(clkAB), .oeAB(oeAB),
    .leBA(leBA), .clkBA(clkBA), .oeBA_n(oeBA_n), .aIn(aIn), .bIn(bIn),
    .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic atNeg();
    @(negedge clk);
  endtask

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R1: reset with both enables requested
    repeat (5) @(posedge clk);
    #1;
    check("R1 bOut", bOut, '0);
    check("R1 aOut", aOut, '0);
    check("R1 bDrive", W'(bDrive), '0);
    check("R1 aDrive", W'(aDrive), '0);
    atNeg(); rst = 1'b0; oeBA_n = 1'b1;
    settle();

    // A-to-B table: controls first, then data, then check
    for (int i = 0; i < NVEC; i++) begin
      atNeg();
      {leAB, clkAB, oeAB} = VEC[i][2*W+3:2*W+1];
      settle();
      atNeg();
      aIn = VEC[i][2*W:W+1];
      settle();
      check($sformatf("R2-R9 vec%0d bOut", i), bOut, VEC[i][W:1]);
      check($sformatf("R6 vec%0d bDrive", i), W'(bDrive), W'(VEC[i][0]));
    end

    // R11: latency from clock pin edge to storage
    atNeg(); leAB = 1'b0; settle();
    atNeg(); aIn = 18'h2468A; clkAB = 1'b0; settle();
    check("R3 held before R11", bOut, 18'h00000);
    atNeg(); clkAB = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R11 unchanged after two edges", bOut, 18'h00000);
    @(posedge clk); #1;
    check("R11 loaded at third edge", bOut, 18'h2468A);

    // R7 R8: B-to-A path
    atNeg(); oeBA_n = 1'b0; leBA = 1'b1; bIn = 18'h0BEEF; settle();
    check("R8 transparent aOut", aOut, 18'h0BEEF);
    check("R7 aDrive on", W'(aDrive), W'(1'b1));
    atNeg(); leBA = 1'b0; settle();
    atNeg(); bIn = 18'h11111; settle();
    check("R8 hold aOut", aOut, 18'h0BEEF);
    atNeg(); clkBA = 1'b1; settle();
    check("R8 capture aOut", aOut, 18'h11111);
    atNeg(); clkBA = 1'b0; settle();
    atNeg(); bIn = 18'h22222; settle();
    check("R8 falling edge ignored", aOut, 18'h11111);
    atNeg(); oeBA_n = 1'b1; settle();
    check("R7 aDrive off", W'(aDrive), '0);
    check("R7 value kept", aOut, 18'h11111);

    // R10: both directions enabled, each fed from the opposite input
    atNeg(); oeAB = 1'b1; oeBA_n = 1'b0; leAB = 1'b1; leBA = 1'b1;
    aIn = 18'h00F0F; bIn = 18'h3C3C3; settle();
    check("R10 bOut from aIn", bOut, 18'h00F0F);
    check("R10 aOut from bIn", aOut, 18'h3C3C3);
    check("R10 both drives", W'({bDrive, aDrive}), W'(2'b11));
    atNeg(); leAB = 1'b0; clkAB = 1'b0; leBA = 1'b0; clkBA = 1'b0; settle();
    atNeg(); bIn = 18'h11223; settle();
    atNeg(); clkBA = 1'b1; settle();
    check("R10 aOut captured", aOut, 18'h11223);
    check("R10 bOut untouched", bOut, 18'h00F0F);

    // R1: reset mid-run clears loaded storage
    atNeg(); rst = 1'b1; settle();
    check("R1 mid bOut", bOut, '0);
    check("R1 mid aOut", aOut, '0);
    check("R1 mid drives", W'({bDrive, aDrive}), '0);
    atNeg(); rst = 1'b0;
    @(posedge clk); #1;
    check("R6 drive after release", W'(bDrive), W'(1'b1));

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule